// File: doc/BRIEF.md
# Symmetric Threshold Gate

This block is a parameterised gate over an `N`-bit input vector that returns three symmetric functions of that vector: majority, threshold at a fixed level `K`, and exact-count at `K`. Every result depends only on how many input bits are high, never on which ones. The ones are tallied into a binary count. Each decision then comes from a greater-or-equal test against a constant. That test is an equality term OR a greater-than term, and both terms are flat AND/OR logic over the count bits.

Two threshold paths are provided. The direct path compares the count against `K`. The padded path reaches the same answer through a single majority function. It extends the input with constant zeros when `2K >= N`, or with constant ones otherwise. The exact-count output comes from two padded thresholds, at `K` and at `K+1`: the first must be set and the second clear. A parameter can place a reset register on all four outputs, which adds one cycle of latency.

Top module: `sym_thr_gate`

## Requirements
- R1: `maj_o` is 1 exactly when the number of high bits of `bits_i` is at least N/2; for odd N the level is (N+1)/2.
- R2: `thr_o` is 1 exactly when the number of high bits is at least K; it is formed by comparing the count with K.
- R3: `thr_pad_o` is the majority of a padded vector. When 2K >= N, the vector is `bits_i` followed by 2K-N zeros. When 2K < N, it is `bits_i` followed by N-2K ones.
- R4: `thr_pad_o` equals `thr_o` for every input pattern and every K from 0 to N+1.
- R5: `exact_o` is 1 exactly when the number of high bits equals K. It is the padded threshold at K AND NOT the padded threshold at K+1.
- R6: With K = 0, `thr_o` and `thr_pad_o` are always 1. With K = N+1, they are always 0 and `exact_o` is always 0.
- R7: Any two input patterns with the same number of high bits give identical outputs, whatever the bit positions.
- R8: With REG_OUT = 1, the outputs show the function of the `bits_i` value sampled at the previous rising clock edge. With REG_OUT = 0, the outputs follow `bits_i` with no clock.
- R9: With REG_OUT = 1, all four outputs are 0 while `rst_n` is low, and they stay 0 until the first rising edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| bits_i | input | N | Input vector whose high bits are counted |
| maj_o | output | 1 | Majority of `bits_i` |
| thr_o | output | 1 | Count of high bits at least K, by direct comparison |
| thr_pad_o | output | 1 | Count of high bits at least K, by padded majority |
| exact_o | output | 1 | Count of high bits equal to K |

## Verification
The hardest case to reach is agreement between the two threshold paths at the extreme levels. At K = 0 and K = N+1 the padding grows to N ones or N+2 zeros. At those levels a wrong pad length or pad polarity only shows on one or two counts. A single instance with a fixed K can never reach these levels. The bench therefore builds one combinational copy for each K from 0 to N+1, drives all of them from the same exhaustive walk over every input pattern, and compares each output with a count of ones computed in the bench.

// File: rtl/sym_thr_pkg.sv
package sym_thr_pkg;

   // bits needed to hold a count from 0 to m
   function automatic int cnt_width(input int m);
      return (m < 1) ? 1 : $clog2(m + 1);
   endfunction

   // smallest count that wins a vote among m inputs
   function automatic int maj_level(input int m);
      return (m + 1) / 2;
   endfunction

endpackage

// File: rtl/sym_popcount.sv
module sym_popcount #(
   parameter int M  = 8,
   parameter int CW = sym_thr_pkg::cnt_width(M)
) (
   input  logic [M-1:0]  vec_i,
   output logic [CW-1:0] cnt_o
);
   if (M < 1) begin : g_bad_m
      $error("sym_popcount: M must be at least 1");
   end
   if (CW < sym_thr_pkg::cnt_width(M)) begin : g_bad_cw
      $error("sym_popcount: CW too narrow for M");
   end

   always_comb begin
      logic [CW-1:0] acc;
      acc = '0;
      for (int i = 0; i < M; i++) begin
         acc = acc + CW'(vec_i[i]);
      end
      cnt_o = acc;
   end
endmodule

// File: rtl/sym_ge_const.sv
module sym_ge_const #(
   parameter int          W = 4,
   parameter int unsigned C = 0
) (
   input  logic [W-1:0] a_i,
   output logic         ge_o
);
   localparam logic [W-1:0] CB = W'(C);

   if (W < 1) begin : g_bad_w
      $error("sym_ge_const: W must be at least 1");
   end
   if (C >= (64'd1 << W)) begin : g_bad_c
      $error("sym_ge_const: constant does not fit in W bits");
   end

   logic [W-1:0] bit_eq;
   logic [W-1:0] above_eq;
   logic [W-1:0] gt_term;

   assign bit_eq = a_i ~^ CB;

   for (genvar i = 0; i < W; i++) begin : g_bit
      // positions strictly above i
      localparam logic [W-1:0] HI_MASK = ~((W'(1) << (i + 1)) - W'(1));
      assign above_eq[i] = &(bit_eq | ~HI_MASK);
      assign gt_term[i]  = a_i[i] & ~CB[i] & above_eq[i];
   end

   logic eq_all;
   logic gt_any;
   assign eq_all = &bit_eq;
   assign gt_any = |gt_term;
   assign ge_o   = eq_all | gt_any;
endmodule

// File: rtl/sym_majority.sv
module sym_majority #(
   parameter int M = 8
) (
   input  logic [M-1:0] vec_i,
   output logic         maj_o
);
   localparam int CW  = sym_thr_pkg::cnt_width(M);
   localparam int LVL = sym_thr_pkg::maj_level(M);

   logic [CW-1:0] cnt;

   sym_popcount #(.M(M), .CW(CW)) cnt_i (
      .vec_i (vec_i),
      .cnt_o (cnt)
   );

   sym_ge_const #(.W(CW), .C(LVL)) cmp_i (
      .a_i  (cnt),
      .ge_o (maj_o)
   );
endmodule

// File: rtl/sym_pad_thr.sv
module sym_pad_thr #(
   parameter int N  = 8,
   parameter int KT = 4
) (
   input  logic [N-1:0] bits_i,
   output logic         thr_o
);
   localparam bit PAD_ZERO = (2 * KT >= N);
   localparam int M        = PAD_ZERO ? 2 * KT : 2 * (N - KT);
   localparam int P        = M - N;

   if (KT < 0 || KT > N + 2) begin : g_bad_kt
      $error("sym_pad_thr: KT out of range");
   end

   logic [M-1:0] padded;

   if (P == 0) begin : g_nopad
      assign padded = bits_i;
   end else if (PAD_ZERO) begin : g_zeros
      assign padded = {{P{1'b0}}, bits_i};
   end else begin : g_ones
      assign padded = {{P{1'b1}}, bits_i};
   end

   sym_majority #(.M(M)) vote_i (
      .vec_i (padded),
      .maj_o (thr_o)
   );
endmodule

// File: rtl/sym_thr_gate.sv
module sym_thr_gate #(
   parameter int N       = 8,
   parameter int K       = 3,
   parameter int REG_OUT = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] bits_i,
   output logic         maj_o,
   output logic         thr_o,
   output logic         thr_pad_o,
   output logic         exact_o
);
   localparam int CW = sym_thr_pkg::cnt_width(N);
   localparam int DW = sym_thr_pkg::cnt_width(N + 1);

   if (N < 1) begin : g_bad_n
      $error("sym_thr_gate: N must be at least 1");
   end
   if (K < 0 || K > N + 1) begin : g_bad_k
      $error("sym_thr_gate: K must lie in 0..N+1");
   end
   if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg
      $error("sym_thr_gate: REG_OUT must be 0 or 1");
   end

   logic [CW-1:0] cnt;
   logic [DW-1:0] cnt_ext;
   logic          maj_c, thr_dir_c, thr_k_c, thr_k1_c, exact_c;

   sym_popcount #(.M(N), .CW(CW)) cnt_i (
      .vec_i (bits_i),
      .cnt_o (cnt)
   );
   assign cnt_ext = DW'(cnt);

   sym_ge_const #(.W(DW), .C(K)) dir_i (
      .a_i  (cnt_ext),
      .ge_o (thr_dir_c)
   );

   sym_majority #(.M(N)) maj_i (
      .vec_i (bits_i),
      .maj_o (maj_c)
   );

   sym_pad_thr #(.N(N), .KT(K)) pad_k_i (
      .bits_i (bits_i),
      .thr_o  (thr_k_c)
   );

   sym_pad_thr #(.N(N), .KT(K + 1)) pad_k1_i (
      .bits_i (bits_i),
      .thr_o  (thr_k1_c)
   );

   assign exact_c = thr_k_c & ~thr_k1_c;

   if (REG_OUT == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            maj_o     <= 1'b0;
            thr_o     <= 1'b0;
            thr_pad_o <= 1'b0;
            exact_o   <= 1'b0;
         end else begin
            maj_o     <= maj_c;
            thr_o     <= thr_dir_c;
            thr_pad_o <= thr_k_c;
            exact_o   <= exact_c;
         end
      end
   end else begin : g_comb
      assign maj_o     = maj_c;
      assign thr_o     = thr_dir_c;
      assign thr_pad_o = thr_k_c;
      assign exact_o   = exact_c;
   end
endmodule

// File: rtl/sym_thr_gate_chk.sv
module sym_thr_gate_chk #(
   parameter int N       = 8,
   parameter int K       = 3,
   parameter int REG_OUT = 1
) (
   input logic         clk,
   input logic         rst_n,
   input logic [N-1:0] bits_i,
   input logic         maj_o,
   input logic         thr_o,
   input logic         thr_pad_o,
   input logic         exact_o
);
   if (REG_OUT == 1) begin : g_seq
      // R4: the two threshold paths agree
      p_paths_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
         thr_o == thr_pad_o);

      // R5: an exact hit is also a threshold hit
      p_exact_in_thr_r5: assert property (@(posedge clk) disable iff (!rst_n)
         exact_o |-> thr_o);

      // R1: all inputs high wins the vote one cycle later
      p_full_vote_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (&bits_i) |=> maj_o);

      // R2: all inputs high meets any level up to N
      p_full_thr_r2: assert property (@(posedge clk) disable iff (!rst_n)
         ((&bits_i) && (K <= N)) |=> thr_o);

      // R6: all inputs low misses every level above zero
      p_empty_thr_r6: assert property (@(posedge clk) disable iff (!rst_n)
         ((bits_i == '0) && (K > 0)) |=> (!thr_o && !exact_o));

      // R9: reset clears all outputs
      p_reset_clear_r9: assert property (@(posedge clk)
         !rst_n |=> (!maj_o && !thr_o && !thr_pad_o && !exact_o));
   end
endmodule

bind sym_thr_gate sym_thr_gate_chk #(.N(N), .K(K), .REG_OUT(REG_OUT)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bits_i    (bits_i),
   .maj_o     (maj_o),
   .thr_o     (thr_o),
   .thr_pad_o (thr_pad_o),
   .exact_o   (exact_o)
);

// File: tb/sym_thr_gate_tb_top.sv
`timescale 1ns/1ps
module sym_thr_gate_tb_top;
   localparam int N  = 6;
   localparam int K  = 2;
   localparam int NO = 5;
   localparam int KO = 3;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic         rst_n = 1'b0;
   logic [N-1:0] bits  = '1;
   logic         maj, thr, thr_pad, exact;
   logic         o_maj, o_thr, o_pad, o_ex;
   logic [N+1:0] sw_maj, sw_thr, sw_pad, sw_ex;

   sym_thr_gate #(.N(N), .K(K), .REG_OUT(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .bits_i(bits),
      .maj_o(maj), .thr_o(thr), .thr_pad_o(thr_pad), .exact_o(exact)
   );

   sym_thr_gate #(.N(NO), .K(KO), .REG_OUT(0)) dut_odd (
      .clk(clk), .rst_n(rst_n), .bits_i(bits[NO-1:0]),
      .maj_o(o_maj), .thr_o(o_thr), .thr_pad_o(o_pad), .exact_o(o_ex)
   );

   for (genvar k = 0; k <= N + 1; k++) begin : sweep_g
      sym_thr_gate #(.N(N), .K(k), .REG_OUT(0)) u (
         .clk(clk), .rst_n(rst_n), .bits_i(bits),
         .maj_o(sw_maj[k]), .thr_o(sw_thr[k]),
         .thr_pad_o(sw_pad[k]), .exact_o(sw_ex[k])
      );
   end

   typedef struct {
      int           due;
      logic [N-1:0] pat;
   } item_t;
   item_t q[$];

   int cyc   = 0;
   int n_chk = 0;
   int n_err = 0;
   bit armed = 1'b0;
   bit done  = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%0b exp=%0b at cycle %0d", req, act, exp, cyc);
      end
   endtask

   task automatic send(input logic [N-1:0] pat);
      @(posedge clk);
      #2;
      bits = pat;
      q.push_back('{due: cyc + 1, pat: pat});
   endtask

   // monitor: samples on the falling edge, away from the register edge
   always @(negedge clk) begin
      if (!rst_n) begin
         if (cyc >= 1) begin
            check("R9 maj", maj, 1'b0);
            check("R9 thr", thr, 1'b0);
            check("R9 pad", thr_pad, 1'b0);
            check("R9 exact", exact, 1'b0);
         end
      end else if (armed) begin
         begin
            int c;
            int co;
            c  = $countones(bits);
            co = $countones(bits[NO-1:0]);
            // R1 odd width: level is (NO+1)/2
            check("R1 odd maj", o_maj, co >= (NO + 1) / 2);
            check("R2 odd thr", o_thr, co >= KO);
            check("R5 odd exact", o_ex, co == KO);
            for (int k = 0; k <= N + 1; k++) begin
               check("R1 sweep maj", sw_maj[k], 2 * c >= N);
               check("R2 sweep thr", sw_thr[k], c >= k);
               // R3 / R4 / R6: padded path matches the count rule at every K
               check("R3 R4 R6 sweep pad", sw_pad[k], c >= k);
               check("R5 sweep exact", sw_ex[k], c == k);
            end
         end
         // R8: registered result is due one edge after the input was set
         while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            int    c;
            it = q.pop_front();
            c  = $countones(it.pat);
            check("R8 R1 maj", maj, 2 * c >= N);
            check("R8 R2 thr", thr, c >= K);
            check("R8 R4 pad", thr_pad, c >= K);
            check("R8 R5 exact", exact, c == K);
         end
      end
   end

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #(20 * 20000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL R8 watchdog act=hung exp=finished");
         summary();
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #2;
      rst_n = 1'b1;
      armed = 1'b1;
      // exhaustive walk covers every count in every bit arrangement (R7)
      for (int v = 0; v < (1 << N); v++) send(N'(v));
      // reverse walk: same counts reached from different neighbours (R7)
      for (int v = (1 << N) - 1; v >= 0; v--) send(N'(v));
      // same-count permutations back to back (R7)
      send(6'b000011);
      send(6'b110000);
      send(6'b100001);
      send(6'b010100);
      while (q.size() > 0) @(posedge clk);
      repeat (2) @(posedge clk);
      // mid-run reset with every input high (R9)
      #2;
      armed = 1'b0;
      bits  = '1;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      done = 1'b1;
      summary();
   end
endmodule